// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Binary Counter

This block is a synchronous binary up-counter made of identical narrow stages. Each stage has its own preset path, a combinational terminal-count flag, and two count-enable inputs. The stages are chained so that together they act as one wide counter with no gating between them. Every register bit in every stage changes on the same rising clock edge, so all count outputs move at the same instant.

A shared active-low load presets the whole chain from a data word on the next rising edge. The load ignores the enables. The shared enable P allows every stage to count. The enable T enters the lowest stage only. Each stage passes its own carry on as the T of the stage above it, so a stage advances only when every stage below it holds all ones. An active-low clear returns the count to zero. An elaboration parameter selects whether the clear waits for the clock edge or acts at once.

The chain's carry output is high when T is high and the full count is all ones. A carry output of this kind can drive the T input of a further chain.

Top module: `bincnt_chain`

## Requirements
- R1: With `clearN` low at a rising edge, `count` is zero after that edge, whatever the other inputs are. With `ASYNC_CLEAR` set to 1, `count` goes to zero as soon as `clearN` goes low, without waiting for an edge.
- R2: With `clearN` high and `loadN` low at a rising edge, `count` takes the value of `dataIn` after that edge, whatever the levels of `enP` and `enT`.
- R3: With `clearN`, `loadN`, `enP` and `enT` all high at a rising edge, `count` increases by one after that edge.
- R4: With `clearN` and `loadN` high and either `enP` or `enT` low at a rising edge, `count` keeps its value.
- R5: Counting from the all-ones value gives zero. With the default parameters, `count` goes from 8'hFF to 8'h00.
- R6: `carryOut` is high exactly when `enT` is high and `count` is all ones. It follows `enT` combinationally, with no clock edge in between.
- R7: When the lower stage counts past all ones, the stage above it advances by one on the same edge. With the default parameters, `count` goes from 8'h0F to 8'h10 and from 8'h3F to 8'h40.
- R8: Clear takes priority over load. With `clearN` and `loadN` both low at a rising edge, `count` is zero after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clearN | input | 1 | Active-low clear; sampled on the edge or asynchronous, set by `ASYNC_CLEAR` |
| loadN | input | 1 | Active-low synchronous preset from `dataIn` |
| enP | input | 1 | Count enable shared by every stage |
| enT | input | 1 | Count enable for the lowest stage; also qualifies `carryOut` |
| dataIn | input | STAGE_W*NUM_STAGES | Preset word |
| count | output | STAGE_W*NUM_STAGES | Current count |
| carryOut | output | 1 | Terminal-count carry of the top stage |

## Verification
A single edge can see both a clear and a load request, or both a load request and both enables high. The bench sets up each of these pairs together: clear with load low, and load low with P and T high. It then checks that only the higher-priority action happens, comparing `count` after the edge with an independent model of the priority order. A third collision is a carry out of the low stage on the same edge as a count in the high stage. This is set up by counting through 8'h0F and 8'h3F. The combinational carry is judged twice at all-ones: once by dropping T between edges, and once by raising T again between edges.

// File: rtl/bincnt_pkg.sv
package bincnt_pkg;
  // Strobes from the per-stage control to the per-stage datapath.
  // At most one strobe is high; none high means hold.
  typedef struct packed {
    logic doClear;
    logic doLoad;
    logic doCount;
  } stageCmd_t;
endpackage

// File: rtl/bincnt_ctrl.sv
module bincnt_ctrl
  import bincnt_pkg::*;
(
  input  logic      clearN,
  input  logic      loadN,
  input  logic      enP,
  input  logic      enT,
  output stageCmd_t cmd
);
  // Fixed priority: clear, then load, then count.
  always_comb begin
    cmd         = '0;
    cmd.doClear = ~clearN;
    cmd.doLoad  = clearN & ~loadN;
    cmd.doCount = clearN & loadN & enP & enT;
  end
endmodule

// File: rtl/bincnt_dp.sv
module bincnt_dp
  import bincnt_pkg::*;
#(
  parameter int STAGE_W     = 4,
  parameter bit ASYNC_CLEAR = 1'b0
) (
  input  logic               clk,
  input  logic               clearN,
  input  stageCmd_t          cmd,
  input  logic               enT,
  input  logic [STAGE_W-1:0] dataIn,
  output logic [STAGE_W-1:0] count,
  output logic               carry
);
  localparam logic [STAGE_W-1:0] TOP_VAL = '1;

  logic [STAGE_W-1:0] countQ;
  logic [STAGE_W-1:0] countD;
  logic               asyncClr;

  // The asynchronous path is wired to a constant low when the clear is synchronous.
  assign asyncClr = ASYNC_CLEAR ? ~clearN : 1'b0;

  always_comb begin
    if (cmd.doClear)      countD = '0;
    else if (cmd.doLoad)  countD = dataIn;
    else if (cmd.doCount) countD = countQ + 1'b1;
    else                  countD = countQ;
  end

  always_ff @(posedge clk or posedge asyncClr) begin
    if (asyncClr) countQ <= '0;
    else          countQ <= countD;
  end

  // Decoded from register state and a static enable, so no counting glitch.
  assign carry = enT & (countQ == TOP_VAL);
  assign count = countQ;
endmodule

// File: rtl/bincnt_stage.sv
module bincnt_stage
  import bincnt_pkg::*;
#(
  parameter int STAGE_W     = 4,
  parameter bit ASYNC_CLEAR = 1'b0
) (
  input  logic               clk,
  input  logic               clearN,
  input  logic               loadN,
  input  logic               enP,
  input  logic               enT,
  input  logic [STAGE_W-1:0] dataIn,
  output logic [STAGE_W-1:0] count,
  output logic               carry
);
  stageCmd_t cmd;

  bincnt_ctrl u_ctrl (
    .clearN (clearN),
    .loadN  (loadN),
    .enP    (enP),
    .enT    (enT),
    .cmd    (cmd)
  );

  bincnt_dp #(.STAGE_W(STAGE_W), .ASYNC_CLEAR(ASYNC_CLEAR)) u_dp (
    .clk    (clk),
    .clearN (clearN),
    .cmd    (cmd),
    .enT    (enT),
    .dataIn (dataIn),
    .count  (count),
    .carry  (carry)
  );
endmodule

// File: rtl/bincnt_chain.sv
module bincnt_chain #(
  parameter int STAGE_W     = 4,
  parameter int NUM_STAGES  = 2,
  parameter bit ASYNC_CLEAR = 1'b0
) (
  input  logic                          clk,
  input  logic                          clearN,
  input  logic                          loadN,
  input  logic                          enP,
  input  logic                          enT,
  input  logic [STAGE_W*NUM_STAGES-1:0] dataIn,
  output logic [STAGE_W*NUM_STAGES-1:0] count,
  output logic                          carryOut
);
  localparam int TOTAL_W = STAGE_W * NUM_STAGES;

  // tChain[k] is the T enable of stage k; tChain[NUM_STAGES] leaves the chain.
  logic [NUM_STAGES:0] tChain;
  assign tChain[0] = enT;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    bincnt_stage #(.STAGE_W(STAGE_W), .ASYNC_CLEAR(ASYNC_CLEAR)) u_stage (
      .clk    (clk),
      .clearN (clearN),
      .loadN  (loadN),
      .enP    (enP),
      .enT    (tChain[k]),
      .dataIn (dataIn[k*STAGE_W +: STAGE_W]),
      .count  (count[k*STAGE_W +: STAGE_W]),
      .carry  (tChain[k+1])
    );
  end

  assign carryOut = tChain[NUM_STAGES];
endmodule

// File: rtl/bincnt_chain_chk.sv
module bincnt_chain_chk #(
  parameter int TOTAL_W = 8
) (
  input logic               clk,
  input logic               clearN,
  input logic               loadN,
  input logic               enP,
  input logic               enT,
  input logic [TOTAL_W-1:0] dataIn,
  input logic [TOTAL_W-1:0] count,
  input logic               carryOut
);
  localparam logic [TOTAL_W-1:0] ALL_ONES = '1;

  // Becomes high after the first edge, so no property looks before time zero.
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    !clearN |=> count == '0);

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!armed)
    clearN && !loadN |=> count == $past(dataIn));

  // R3
  count_inc_chk: assert property (@(posedge clk) disable iff (!armed)
    clearN && loadN && enP && enT |=> count == $past(count) + 1'b1);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!armed)
    clearN && loadN && !(enP && enT) |=> $stable(count));

  // R6
  carry_flag_chk: assert property (@(posedge clk) disable iff (!armed)
    carryOut == (enT && (count == ALL_ONES)));

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    clearN && loadN && enP && enT && count == ALL_ONES |=> count == '0);
endmodule

bind bincnt_chain bincnt_chain_chk #(.TOTAL_W(TOTAL_W)) u_chk (
  .clk      (clk),
  .clearN   (clearN),
  .loadN    (loadN),
  .enP      (enP),
  .enT      (enT),
  .dataIn   (dataIn),
  .count    (count),
  .carryOut (carryOut)
);

// File: tb/bincnt_chain_tb.sv
module bincnt_chain_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clearN = 1'b1;
  logic         loadN = 1'b1;
  logic         enP = 1'b0;
  logic         enT = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] count;
  logic         carryOut;

  always #10 clk = ~clk;

  bincnt_chain u_dut (
    .clk      (clk),
    .clearN   (clearN),
    .loadN    (loadN),
    .enP      (enP),
    .enT      (enT),
    .dataIn   (dataIn),
    .count    (count),
    .carryOut (carryOut)
  );

  typedef struct {
    logic [W-1:0] expCount;
    logic         expCarry;
    string        tag;
  } expItem_t;

  expItem_t     expQ[$];
  logic [W-1:0] model = '0;
  int           total = 0;
  int           fails = 0;
  bit           finished = 1'b0;

  task automatic report(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: set inputs between edges, predict the next state, queue it.
  task automatic step(input logic c, input logic l, input logic p, input logic t,
                      input logic [W-1:0] d, input string tag);
    expItem_t it;
    @(negedge clk);
    clearN = c; loadN = l; enP = p; enT = t; dataIn = d;
    if (!c)          model = '0;
    else if (!l)     model = d;
    else if (p && t) model = model + 1'b1;
    it.expCount = model;
    it.expCarry = t && (model == '1);
    it.tag      = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compare shortly after each edge, before the next drive.
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        report(it.tag, "count", int'(count), int'(it.expCount));
        report(it.tag, "carry", int'(carryOut), int'(it.expCarry));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(0, 1, 1, 1, 8'h5A, "R1");    // clear while enables high
    step(1, 0, 0, 0, 8'hA5, "R2");    // load with both enables low
    step(1, 0, 1, 1, 8'h0E, "R2");    // load wins over count
    step(1, 1, 1, 1, 8'h00, "R3");    // 0E -> 0F
    step(1, 1, 1, 1, 8'h00, "R7");    // 0F -> 10
    step(1, 1, 0, 1, 8'h00, "R4");    // P low holds
    step(1, 1, 1, 0, 8'h00, "R4");    // T low holds
    step(1, 0, 1, 1, 8'h3E, "R2");
    step(1, 1, 1, 1, 8'h00, "R3");    // 3F
    step(1, 1, 1, 1, 8'h00, "R7");    // 40
    step(1, 0, 0, 1, 8'hFE, "R2");
    step(1, 1, 1, 1, 8'h00, "R6");    // FF, carry high
    step(1, 1, 1, 0, 8'h00, "R6");    // T low: hold, carry low
    // Raise T between edges: carry must follow without a clock edge.
    @(negedge clk); #3;
    enT = 1'b1; #1;
    report("R6", "comb carry", int'(carryOut), 1);
    enT = 1'b0; #1;
    report("R6", "comb carry", int'(carryOut), 0);
    step(1, 1, 1, 1, 8'h00, "R5");    // FF -> 00
    step(1, 1, 1, 1, 8'h00, "R3");    // 01
    step(0, 0, 1, 1, 8'hC3, "R8");    // clear beats load
    step(1, 1, 0, 0, 8'h77, "R4");    // dataIn ignored while holding
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule